// File: doc/BRIEF.md
# UART Interrupt Pending and Identification Logic

This block holds the interrupt state of a 16550-style serial port register file. It tracks two interrupt sources: receive data available (RX) and transmit holding register empty (TX). Each source is gated by its own enable bit in an internal enable register. A source that is armed does not become pending at once. A per-source delay timer runs first, and the pending bit is set only when that timer expires. Arming a source again restarts its timer from the full delay. Register accesses can cancel a running timer. The block encodes the highest-priority pending source into an identification byte and drives one level interrupt line to the platform.

The host side drives single-cycle strobes: one for a read of the receive buffer, one for a write of the transmit holding register, one for a write of the enable register (with the two enable bits it carries), and one for a read of the identification register. The serial side drives a level flag, `rx_avail`, which is high while received bytes remain. When `rx_avail` is sampled in the same cycle as a receive-buffer read, it means data remains after the byte being read. The serial side also drives a one-cycle pulse, `rx_new`, when a byte arrives. The block carries no data stream, so it has no valid/ready handshake. Every strobe is taken in the cycle it is high, and the block never stalls the host.

The delay is given as `DELAY_PS` picoseconds and converted to `DELAY_CYC` clock cycles using `CLK_PERIOD_PS`. The defaults are 225 ns at 5 ns, which gives 45 cycles. All timing below is counted in clock edges.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset both pending bits and both timers are clear, `iir` reads 8'h01 and `irq` is low.
- R2: A source whose timer is armed by the edge that samples a strobe becomes pending exactly `DELAY_CYC` edges later. Before that edge it is not pending.
- R3: Arming a source whose timer is already running restarts the full `DELAY_CYC` count from the new arming edge.
- R4: A receive-buffer read clears RX pending on the next edge. If `rx_avail` is high and RX is enabled, the RX timer is re-armed; otherwise any running RX timer is cancelled.
- R5: A transmit-holding write clears TX pending on the next edge. If TX is enabled, the TX timer is re-armed; otherwise any running TX timer is cancelled.
- R6: `iir` is 8'h04 when RX is pending (RX takes priority), 8'h02 when only TX is pending, and 8'h01 when nothing is pending. Bit 0 set means no interrupt is pending, and bits 3:1 carry the source ID (2 for RX, 1 for TX).
- R7: An identification read while `iir` shows 8'h02 clears TX pending and cancels the TX timer. An identification read while `iir` shows 8'h04 leaves RX pending.
- R8: An enable-register write with the TX enable bit clear cancels the TX timer and clears TX pending. The same holds for the RX enable bit with the RX timer and RX pending.
- R9: An enable-register write with the RX enable bit set arms the RX timer only while `rx_avail` is high. A write with the TX enable bit set always arms the TX timer.
- R10: An `rx_new` pulse while RX is enabled sets RX pending on the next edge, with no delay. While RX is disabled, the pulse has no effect.
- R11: `irq` is high exactly when at least one source is pending. It falls only once both RX and TX pending are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rbr_rd | input | 1 | Receive-buffer read strobe |
| thr_wr | input | 1 | Transmit-holding write strobe |
| ier_wr | input | 1 | Enable-register write strobe |
| ier_rx_en_in | input | 1 | RX enable bit written with `ier_wr` |
| ier_tx_en_in | input | 1 | TX enable bit written with `ier_wr` |
| iir_rd | input | 1 | Identification-register read strobe |
| rx_avail | input | 1 | Received data remains (level) |
| rx_new | input | 1 | One-cycle pulse when a byte arrives |
| iir | output | 8 | Identification byte (encoding as in R6) |
| irq | output | 1 | Interrupt line to the platform |

## Verification
The hardest case to reach is a timer that is cancelled or restarted partway through its count. Its only visible effect is the absence of a pending bit 45 edges after the first arming, so a stuck or unrestarted timer looks correct unless the bench samples exactly that edge. The stimulus arms a source, waits part of the delay, then issues the restarting or cancelling access. Expectations are queued for both the original expiry edge and the new one. RX and TX are also made pending together, so that the priority rule decides what an identification read may clear.

// File: rtl/uart_irq_pkg.sv
`timescale 1ns/1ps
package uart_irq_pkg;
  localparam logic [7:0] IIR_NONE = 8'h01;
  localparam logic [7:0] IIR_RX   = 8'h04;
  localparam logic [7:0] IIR_TX   = 8'h02;

  localparam int SRC_RX = 0;
  localparam int SRC_TX = 1;
  localparam int NSRC   = 2;

  typedef struct packed {
    logic arm;      // (re)start the delay timer
    logic cancel;   // stop the delay timer
    logic clr;      // clear the pending bit
    logic set_now;  // set pending without delay
  } src_ctl_t;
endpackage

// File: rtl/irq_delay_timer.sv
`timescale 1ns/1ps
module irq_delay_timer #(
  parameter int DELAY_CYC = 45
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic cancel,
  output logic fire
);
  localparam int CW = $clog2(DELAY_CYC + 1);

  logic [CW-1:0] cnt;
  logic          run;

  // Expiry is suppressed when the same cycle restarts or cancels the timer.
  assign fire = run && (cnt == CW'(1)) && !arm && !cancel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (arm) begin
      run <= 1'b1;
      cnt <= CW'(DELAY_CYC);
    end else if (cancel) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (run) begin
      cnt <= cnt - CW'(1);
      if (cnt == CW'(1)) run <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_source.sv
`timescale 1ns/1ps
module irq_source
  import uart_irq_pkg::*;
#(
  parameter int DELAY_CYC = 45
) (
  input  logic     clk,
  input  logic     rst_n,
  input  src_ctl_t ctl,
  output logic     pending
);
  logic fire;

  irq_delay_timer #(.DELAY_CYC(DELAY_CYC)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .arm    (ctl.arm),
    .cancel (ctl.cancel),
    .fire   (fire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) pending <= 1'b0;
    else        pending <= (pending && !ctl.clr) || fire || ctl.set_now;
  end
endmodule

// File: rtl/iir_encoder.sv
`timescale 1ns/1ps
module iir_encoder
  import uart_irq_pkg::*;
(
  input  logic       rx_pend,
  input  logic       tx_pend,
  output logic [7:0] iir
);
  always_comb begin
    if (rx_pend)      iir = IIR_RX;
    else if (tx_pend) iir = IIR_TX;
    else              iir = IIR_NONE;
  end
endmodule

// File: rtl/uart_irq_ident.sv
`timescale 1ns/1ps
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int CLK_PERIOD_PS = 5000,
  parameter int DELAY_PS      = 225000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rbr_rd,
  input  logic       thr_wr,
  input  logic       ier_wr,
  input  logic       ier_rx_en_in,
  input  logic       ier_tx_en_in,
  input  logic       iir_rd,
  input  logic       rx_avail,
  input  logic       rx_new,
  output logic [7:0] iir,
  output logic       irq
);
  localparam int RAW_CYC   = (DELAY_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int DELAY_CYC = (RAW_CYC < 1) ? 1 : RAW_CYC;

  logic     ier_rx_q, ier_tx_q;
  src_ctl_t ctl  [NSRC];
  logic     pend [NSRC];
  logic     rx_rearm, tx_from_iir;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ier_rx_q <= 1'b0;
      ier_tx_q <= 1'b0;
    end else if (ier_wr) begin
      ier_rx_q <= ier_rx_en_in;
      ier_tx_q <= ier_tx_en_in;
    end
  end

  assign rx_rearm    = rx_avail && ier_rx_q;
  assign tx_from_iir = iir_rd && pend[SRC_TX] && !pend[SRC_RX];

  always_comb begin
    ctl[SRC_RX].arm     = (rbr_rd && rx_rearm) || (ier_wr && ier_rx_en_in && rx_avail);
    ctl[SRC_RX].cancel  = (rbr_rd && !rx_rearm) || (ier_wr && !ier_rx_en_in);
    ctl[SRC_RX].clr     = rbr_rd || (ier_wr && !ier_rx_en_in);
    ctl[SRC_RX].set_now = rx_new && ier_rx_q;

    ctl[SRC_TX].arm     = (thr_wr && ier_tx_q) || (ier_wr && ier_tx_en_in);
    ctl[SRC_TX].cancel  = (thr_wr && !ier_tx_q) || (ier_wr && !ier_tx_en_in) || tx_from_iir;
    ctl[SRC_TX].clr     = thr_wr || (ier_wr && !ier_tx_en_in) || tx_from_iir;
    ctl[SRC_TX].set_now = 1'b0;
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    irq_source #(.DELAY_CYC(DELAY_CYC)) u_src (
      .clk     (clk),
      .rst_n   (rst_n),
      .ctl     (ctl[s]),
      .pending (pend[s])
    );
  end

  iir_encoder u_enc (
    .rx_pend (pend[SRC_RX]),
    .tx_pend (pend[SRC_TX]),
    .iir     (iir)
  );

  assign irq = pend[SRC_RX] || pend[SRC_TX];
endmodule

// File: rtl/uart_irq_chk.sv
`timescale 1ns/1ps
module uart_irq_chk
  import uart_irq_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       rbr_rd,
  input logic       thr_wr,
  input logic       ier_wr,
  input logic       ier_rx_en_in,
  input logic       iir_rd,
  input logic       rx_new,
  input logic       ier_rx_q,
  input logic [7:0] iir,
  input logic       irq
);
  a_r6_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
    (iir == IIR_NONE) || (iir == IIR_RX) || (iir == IIR_TX));

  a_r11_line_vs_id: assert property (@(posedge clk) disable iff (!rst_n)
    irq == !iir[0]);

  a_r10_rx_arrival: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_new && ier_rx_q) |=> (iir == IIR_RX));

  a_r5_thr_clears_tx: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr |=> (iir != IIR_TX));

  a_r7_iir_clears_tx: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_rd && iir == IIR_TX) |=> (iir != IIR_TX));

  a_r7_iir_keeps_rx: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_rd && iir == IIR_RX && !rbr_rd && !(ier_wr && !ier_rx_en_in)) |=> (iir == IIR_RX));

  a_r8_rx_disable: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_wr && !ier_rx_en_in && !(rx_new && ier_rx_q)) |=> (iir != IIR_RX));
endmodule

bind uart_irq_ident uart_irq_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rbr_rd       (rbr_rd),
  .thr_wr       (thr_wr),
  .ier_wr       (ier_wr),
  .ier_rx_en_in (ier_rx_en_in),
  .iir_rd       (iir_rd),
  .rx_new       (rx_new),
  .ier_rx_q     (ier_rx_q),
  .iir          (iir),
  .irq          (irq)
);

// File: tb/sim_uart_irq_ident.sv
`timescale 1ns/1ps
module sim_uart_irq_ident;
  localparam int D = 45;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rbr_rd = 0, thr_wr = 0, ier_wr = 0, ier_rx_en_in = 0, ier_tx_en_in = 0;
  logic iir_rd = 0, rx_avail = 0, rx_new = 0;
  logic [7:0] iir;
  logic irq;

  int cyc = 0;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  typedef struct {
    int         at;
    logic [7:0] iir;
    logic       irq;
    string      tag;
  } exp_t;
  exp_t q[$];
  exp_t e;

  uart_irq_ident u0 (
    .clk(clk), .rst_n(rst_n), .rbr_rd(rbr_rd), .thr_wr(thr_wr), .ier_wr(ier_wr),
    .ier_rx_en_in(ier_rx_en_in), .ier_tx_en_in(ier_tx_en_in), .iir_rd(iir_rd),
    .rx_avail(rx_avail), .rx_new(rx_new), .iir(iir), .irq(irq)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compare queued expectations in the cycle they are due.
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].at <= cyc) begin
      e = q.pop_front();
      n_chk++;
      if (e.at != cyc) begin
        n_fail++;
        $display("FAIL %s: expectation for cycle %0d missed (now %0d)", e.tag, e.at, cyc);
      end else if (iir !== e.iir || irq !== e.irq) begin
        n_fail++;
        $display("FAIL %s: cycle %0d iir=%h irq=%b expected iir=%h irq=%b",
                 e.tag, cyc, iir, irq, e.iir, e.irq);
      end
    end
  end

  task automatic expect_at(input int at, input logic [7:0] v, input logic l, input string tag);
    exp_t x;
    x.at = at; x.iir = v; x.irq = l; x.tag = tag;
    q.push_back(x);
  endtask

  // Driver: drive one access at a negedge; caller queues expectations, then releases.
  task automatic step(input logic rb, input logic tw, input logic iw, input logic ir,
                      input logic rn, input logic rxe, input logic txe, output int t);
    @(negedge clk);
    t = cyc;
    rbr_rd = rb; thr_wr = tw; ier_wr = iw; iir_rd = ir; rx_new = rn;
    ier_rx_en_in = rxe; ier_tx_en_in = txe;
  endtask

  task automatic rel();
    @(negedge clk);
    rbr_rd = 0; thr_wr = 0; ier_wr = 0; iir_rd = 0; rx_new = 0;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete (got cycle %0d, expected end before)", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int t, t2;
    repeat (4) @(negedge clk);
    rst_n = 1;
    expect_at(cyc + 1, 8'h01, 1'b0, "R1");
    wait_until(cyc + 2);

    // R9/R2: enabling TX arms the timer; pending exactly D edges later
    step(0,0,1,0,0,0,1,t);
    expect_at(t + D,     8'h01, 1'b0, "R2");
    expect_at(t + D + 1, 8'h02, 1'b1, "R2 R9");
    rel(); wait_until(t + D + 2);

    // R7: identification read reporting TX clears it
    step(0,0,0,1,0,0,0,t);
    expect_at(t + 1, 8'h01, 1'b0, "R7");
    rel();

    // R3: re-arm partway restarts the full delay
    step(0,0,1,0,0,0,1,t);
    rel(); repeat (20) @(negedge clk);
    step(0,1,0,0,0,0,0,t2);
    expect_at(t + D + 1,  8'h01, 1'b0, "R3");
    expect_at(t2 + D,     8'h01, 1'b0, "R3");
    expect_at(t2 + D + 1, 8'h02, 1'b1, "R3");
    rel(); wait_until(t2 + D + 2);

    // R5: THR write clears TX and re-arms while enabled
    step(0,1,0,0,0,0,0,t);
    expect_at(t + 1,     8'h01, 1'b0, "R5");
    expect_at(t + D + 1, 8'h02, 1'b1, "R5");
    rel(); wait_until(t + D + 2);

    // R8: disabling TX clears pending
    step(0,0,1,0,0,0,0,t);
    expect_at(t + 1, 8'h01, 1'b0, "R8");
    rel();

    // R5: THR write with TX disabled does not arm
    step(0,1,0,0,0,0,0,t);
    expect_at(t + D + 1, 8'h01, 1'b0, "R5");
    rel(); wait_until(t + D + 2);

    // R8: disabling TX cancels a running timer
    step(0,0,1,0,0,0,1,t);
    rel(); repeat (10) @(negedge clk);
    step(0,0,1,0,0,0,0,t2);
    expect_at(t + D + 1, 8'h01, 1'b0, "R8");
    rel(); wait_until(t + D + 2);

    // R10: arrival with RX disabled is ignored
    step(0,0,0,0,1,0,0,t);
    expect_at(t + 1, 8'h01, 1'b0, "R10");
    rel();
    // R9: RX enable with no data does not arm
    step(0,0,1,0,0,1,0,t);
    expect_at(t + D + 1, 8'h01, 1'b0, "R9");
    rel(); wait_until(t + D + 2);
    // R10: arrival with RX enabled sets RX at once
    rx_avail = 1;
    step(0,0,0,0,1,1,0,t);
    expect_at(t + 1, 8'h04, 1'b1, "R10");
    rel(); wait_until(t + 2);

    // R6: RX has priority over TX
    step(0,0,1,0,0,1,1,t);
    expect_at(t + 1,     8'h04, 1'b1, "R6");
    expect_at(t + D + 1, 8'h04, 1'b1, "R6");
    rel(); wait_until(t + D + 2);

    // R7: identification read reporting RX keeps RX
    step(0,0,0,1,0,1,1,t);
    expect_at(t + 1, 8'h04, 1'b1, "R7");
    rel();

    // R4/R11: RBR read with no more data clears RX; TX keeps the line high
    rx_avail = 0;
    step(1,0,0,0,0,1,1,t);
    expect_at(t + 1, 8'h02, 1'b1, "R4 R11");
    rel();
    step(0,0,0,1,0,1,1,t);
    expect_at(t + 1, 8'h01, 1'b0, "R11");
    rel();

    // R4: RBR read with data remaining re-arms RX
    rx_avail = 1;
    step(0,0,0,0,1,1,1,t);
    rel();
    step(1,0,0,0,0,1,1,t);
    expect_at(t + 1,     8'h01, 1'b0, "R4");
    expect_at(t + D + 1, 8'h04, 1'b1, "R4");
    rel(); wait_until(t + D + 2);

    // R4: RBR read with no data left cancels a running RX timer
    step(1,0,0,0,0,1,1,t);
    expect_at(t + 1, 8'h01, 1'b0, "R4");
    rel(); repeat (10) @(negedge clk);
    rx_avail = 0;
    step(1,0,0,0,0,1,1,t2);
    expect_at(t + D + 1, 8'h01, 1'b0, "R4");
    rel(); wait_until(t + D + 2);

    // R8: disabling RX clears RX pending
    rx_avail = 1;
    step(0,0,0,0,1,1,1,t);
    expect_at(t + 1, 8'h04, 1'b1, "R10");
    rel();
    step(0,0,1,0,0,0,0,t);
    expect_at(t + 1, 8'h01, 1'b0, "R8");
    rel(); wait_until(t + 4);

    if (q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL end: %0d expectations left, expected 0", q.size());
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule